// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Controller

This block sits beside the arithmetic datapath of a floating-point unit and keeps track of the five exception conditions an IEEE-754 unit must report: invalid operation, divide by zero, overflow, underflow and inexact. It holds three 5-bit registers:

- a trap-enable mask;
- an accrued (sticky) flag set that software may read and rewrite;
- a per-instruction flag set that is replaced each time an instruction completes.

When a completing instruction raises an exception whose trap is enabled, the block latches a trap cause, the operation code and the destination format tag. It then raises a trap request and holds it until the handler acknowledges. While the request is pending it refuses further results by dropping its ready output.

By default traps are edge-based. Only the exceptions of the instruction that just completed can start a trap. Rewriting the enables or the sticky flags never does. A parameter selects a level-sensitive variant instead. In that variant a trap is requested whenever any sticky flag meets its enable, and it comes back after each acknowledge until software clears the flag or the enable.

Top module: `fpx_trap_ctrl`

## Requirements
- R1: While `rst_n` is low, the enable, sticky and current registers, the trap request, the cause, the operation code and the format outputs are all zero.
- R2: An accepted instruction (`inst_valid` and `inst_ready` both high) replaces the current register with its flags from the next cycle on. Without an accepted instruction, the current register keeps its value.
- R3: In edge mode, an accepted instruction whose flags share a set bit with the enable register raises `trap_req` in the next cycle. At the same time the block presents the enabled flags as the cause, together with that instruction's operation code and format tag.
- R4: In edge mode, no software write to the enable or sticky register raises `trap_req`, whatever bits the sticky register already holds.
- R5: In edge mode, an accepted instruction ORs into the sticky register every flag it raised that is not in the trap cause. Sticky bits only grow unless software writes them.
- R6: When overflow or underflow is part of a trap cause, the inexact bit of the cause is cleared. Inexact then counts as an untrapped flag for R5.
- R7: `trap_req` and its cause, operation code and format stay unchanged until a cycle with `trap_ack` high. After that cycle `trap_req` is low and the cause reads zero.
- R8: `inst_ready` is low exactly while `trap_req` is high. An instruction offered while not ready leaves every register unchanged.
- R9: When a sticky write and an accepted instruction fall in the same cycle, the written value is applied first and the instruction's untrapped flags are ORed on top.
- R10: In level mode, `trap_req` rises one cycle after the registered value of (sticky AND enable) becomes non-zero, including right after software enables traps. The cause is that value reduced as in R6. The request is raised again after an acknowledge unless the handler clears the flag or the enable in the acknowledge cycle.
- R11: Bits 4 down to 0 of every flag register and port are invalid, divide by zero, overflow, underflow and inexact. With `reg_sel`=0 a write targets the enable register; with `reg_sel`=1 it targets the sticky register. A register not written keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| inst_valid | input | 1 | An instruction completes this cycle |
| inst_flags | input | 5 | Exceptions raised by that instruction |
| inst_op | input | OP_W | Operation code of that instruction |
| inst_fmt | input | FMT_W | Destination format tag of that instruction |
| inst_ready | output | 1 | Block accepts an instruction result |
| reg_wr_en | input | 1 | Software register write strobe |
| reg_sel | input | 1 | Write target: 0 enable, 1 sticky |
| reg_wdata | input | 5 | Value written |
| exc_enable | output | 5 | Trap-enable register |
| exc_sticky | output | 5 | Accrued flag register |
| exc_current | output | 5 | Flags of the last accepted instruction |
| trap_req | output | 1 | Trap pending for the handler |
| trap_cause | output | 5 | Exceptions that caused the pending trap |
| trap_op | output | OP_W | Operation code latched with the trap |
| trap_fmt | output | FMT_W | Format tag latched with the trap |
| trap_ack | input | 1 | One-cycle acknowledge from the handler |

## Verification
The assertions watch, on every cycle, that a pending trap and its cause hold until an acknowledge, and that a cause never carries inexact next to overflow or underflow. They also check that ready and request stay complementary, that the current register tracks accepted flags, and that in edge mode a cycle without an accepted instruction never starts a trap. The bench sweeps all 32 enable masks against all 32 flag patterns and compares cause and sticky results with values it works out bit by bit. Its scenarios cover the cases only a sequence can show: enabling traps over set sticky flags, a write colliding with a completion, a blocked instruction, and the repeat-until-cleared loop of level mode.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int EXC_W = 5;

  // bit positions, also the order software sees
  localparam int EX_IX  = 0;
  localparam int EX_UF  = 1;
  localparam int EX_OF  = 2;
  localparam int EX_DZ  = 3;
  localparam int EX_INV = 4;

  typedef logic [EXC_W-1:0] exc_t;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_STICKY = 1'b1
  } reg_sel_e;

  // overflow/underflow traps supersede a separate inexact trap
  function automatic exc_t apply_precedence(exc_t hit);
    exc_t res;
    res = hit;
    if (hit[EX_OF] || hit[EX_UF]) begin
      res[EX_IX] = 1'b0;
    end
    return res;
  endfunction

endpackage

// File: rtl/fpx_status_regs.sv
module fpx_status_regs
  import fpx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_sel,
  input  exc_t wr_data,
  input  logic accept,
  input  exc_t flags,
  input  exc_t sticky_add,
  output exc_t enable_q,
  output exc_t sticky_q,
  output exc_t curr_q
);

  exc_t enable_d;
  exc_t sticky_d;
  exc_t curr_d;
  exc_t sticky_base;
  logic en_we;
  logic st_we;

  always_comb begin
    en_we       = wr_en && (wr_sel == SEL_ENABLE);
    st_we       = wr_en && (wr_sel == SEL_STICKY);
    enable_d    = en_we ? wr_data : enable_q;
    sticky_base = st_we ? wr_data : sticky_q;
    sticky_d    = sticky_base | (accept ? sticky_add : '0);
    curr_d      = accept ? flags : curr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      sticky_q <= '0;
      curr_q   <= '0;
    end else begin
      enable_q <= enable_d;
      sticky_q <= sticky_d;
      curr_q   <= curr_d;
    end
  end

endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
  import fpx_pkg::*;
#(
  parameter int LEVEL_MODE = 0
) (
  input  logic accept,
  input  exc_t flags,
  input  exc_t enable_q,
  input  exc_t sticky_q,
  output logic raise,
  output exc_t cause,
  output exc_t sticky_add
);

  localparam bit IS_LEVEL = (LEVEL_MODE != 0);

  exc_t edge_hit;
  exc_t level_hit;
  exc_t hit;

  always_comb begin
    edge_hit   = accept ? (flags & enable_q) : '0;
    level_hit  = sticky_q & enable_q;
    hit        = IS_LEVEL ? level_hit : edge_hit;
    cause      = apply_precedence(hit);
    raise      = |hit;
    // level mode accrues every flag, edge mode only the untrapped ones
    sticky_add = IS_LEVEL ? flags : (flags & ~cause);
  end

endmodule

// File: rtl/fpx_cause_latch.sv
module fpx_cause_latch
  import fpx_pkg::*;
#(
  parameter int OP_W       = 4,
  parameter int FMT_W      = 2,
  parameter int LEVEL_MODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise,
  input  exc_t             cause,
  input  logic             accept,
  input  logic [OP_W-1:0]  op,
  input  logic [FMT_W-1:0] fmt,
  input  logic             ack,
  output logic             pend_q,
  output exc_t             cause_q,
  output logic [OP_W-1:0]  op_q,
  output logic [FMT_W-1:0] fmt_q
);

  localparam bit IS_LEVEL = (LEVEL_MODE != 0);

  logic             pend_d;
  exc_t             cause_d;
  logic [OP_W-1:0]  op_d;
  logic [FMT_W-1:0] fmt_d;
  logic [OP_W-1:0]  last_op_q;
  logic [OP_W-1:0]  last_op_d;
  logic [FMT_W-1:0] last_fmt_q;
  logic [FMT_W-1:0] last_fmt_d;
  logic [OP_W-1:0]  src_op;
  logic [FMT_W-1:0] src_fmt;
  logic             capture;
  logic             release_t;

  always_comb begin
    last_op_d  = accept ? op  : last_op_q;
    last_fmt_d = accept ? fmt : last_fmt_q;
    src_op     = IS_LEVEL ? last_op_q  : op;
    src_fmt    = IS_LEVEL ? last_fmt_q : fmt;
    capture    = !pend_q && raise;
    release_t  = pend_q && ack;

    pend_d  = pend_q;
    cause_d = cause_q;
    op_d    = op_q;
    fmt_d   = fmt_q;
    if (capture) begin
      pend_d  = 1'b1;
      cause_d = cause;
      op_d    = src_op;
      fmt_d   = src_fmt;
    end else if (release_t) begin
      pend_d  = 1'b0;
      cause_d = '0;
      op_d    = '0;
      fmt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      cause_q    <= '0;
      op_q       <= '0;
      fmt_q      <= '0;
      last_op_q  <= '0;
      last_fmt_q <= '0;
    end else begin
      pend_q     <= pend_d;
      cause_q    <= cause_d;
      op_q       <= op_d;
      fmt_q      <= fmt_d;
      last_op_q  <= last_op_d;
      last_fmt_q <= last_fmt_d;
    end
  end

endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
  import fpx_pkg::*;
#(
  parameter int OP_W       = 4,
  parameter int FMT_W      = 2,
  parameter int LEVEL_MODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_valid,
  input  logic [4:0]       inst_flags,
  input  logic [OP_W-1:0]  inst_op,
  input  logic [FMT_W-1:0] inst_fmt,
  output logic             inst_ready,
  input  logic             reg_wr_en,
  input  logic             reg_sel,
  input  logic [4:0]       reg_wdata,
  output logic [4:0]       exc_enable,
  output logic [4:0]       exc_sticky,
  output logic [4:0]       exc_current,
  output logic             trap_req,
  output logic [4:0]       trap_cause,
  output logic [OP_W-1:0]  trap_op,
  output logic [FMT_W-1:0] trap_fmt,
  input  logic             trap_ack
);

  logic accept;
  logic raise;
  exc_t cause;
  exc_t sticky_add;
  exc_t enable_q;
  exc_t sticky_q;
  exc_t curr_q;
  exc_t cause_q;
  logic pend_q;

  assign inst_ready = !pend_q;
  assign accept     = inst_valid && !pend_q;

  fpx_status_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .wr_sel     (reg_sel),
    .wr_data    (reg_wdata),
    .accept     (accept),
    .flags      (inst_flags),
    .sticky_add (sticky_add),
    .enable_q   (enable_q),
    .sticky_q   (sticky_q),
    .curr_q     (curr_q)
  );

  fpx_trap_eval #(
    .LEVEL_MODE (LEVEL_MODE)
  ) u_eval (
    .accept     (accept),
    .flags      (inst_flags),
    .enable_q   (enable_q),
    .sticky_q   (sticky_q),
    .raise      (raise),
    .cause      (cause),
    .sticky_add (sticky_add)
  );

  fpx_cause_latch #(
    .OP_W       (OP_W),
    .FMT_W      (FMT_W),
    .LEVEL_MODE (LEVEL_MODE)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise   (raise),
    .cause   (cause),
    .accept  (accept),
    .op      (inst_op),
    .fmt     (inst_fmt),
    .ack     (trap_ack),
    .pend_q  (pend_q),
    .cause_q (cause_q),
    .op_q    (trap_op),
    .fmt_q   (trap_fmt)
  );

  assign exc_enable  = enable_q;
  assign exc_sticky  = sticky_q;
  assign exc_current = curr_q;
  assign trap_req    = pend_q;
  assign trap_cause  = cause_q;

endmodule

// File: rtl/fpx_trap_ctrl_chk.sv
module fpx_trap_ctrl_chk #(
  parameter int OP_W       = 4,
  parameter int FMT_W      = 2,
  parameter int LEVEL_MODE = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inst_valid,
  input logic [4:0]       inst_flags,
  input logic             inst_ready,
  input logic             reg_wr_en,
  input logic             reg_sel,
  input logic [4:0]       exc_enable,
  input logic [4:0]       exc_sticky,
  input logic [4:0]       exc_current,
  input logic             trap_req,
  input logic [4:0]       trap_cause,
  input logic [OP_W-1:0]  trap_op,
  input logic [FMT_W-1:0] trap_fmt,
  input logic             trap_ack
);

  logic acc;
  assign acc = inst_valid && inst_ready;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_ack) |=> (trap_req && $stable(trap_cause)
                                 && $stable(trap_op) && $stable(trap_fmt)));

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_ack) |=> !trap_req);

  p_precedence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && (trap_cause[2] || trap_cause[1])) |-> !trap_cause[0]);

  p_cause_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause != 5'd0));

  p_edge_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (LEVEL_MODE == 0 && acc && ((inst_flags & exc_enable) != 5'd0)) |=> trap_req);

  p_no_sw_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (LEVEL_MODE == 0 && !trap_req && !acc) |=> !trap_req);

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !inst_ready);

  p_curr_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (exc_current == $past(inst_flags)));

  p_curr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(exc_current));

  p_enable_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && !reg_sel) |=> $stable(exc_enable));

  p_sticky_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_sel) |=> ((exc_sticky & $past(exc_sticky)) == $past(exc_sticky)));

endmodule

bind fpx_trap_ctrl fpx_trap_ctrl_chk #(
  .OP_W       (OP_W),
  .FMT_W      (FMT_W),
  .LEVEL_MODE (LEVEL_MODE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inst_valid  (inst_valid),
  .inst_flags  (inst_flags),
  .inst_ready  (inst_ready),
  .reg_wr_en   (reg_wr_en),
  .reg_sel     (reg_sel),
  .exc_enable  (exc_enable),
  .exc_sticky  (exc_sticky),
  .exc_current (exc_current),
  .trap_req    (trap_req),
  .trap_cause  (trap_cause),
  .trap_op     (trap_op),
  .trap_fmt    (trap_fmt),
  .trap_ack    (trap_ack)
);

// File: tb/fpx_trap_ctrl_bench.sv
`timescale 1ns/1ps
module fpx_trap_ctrl_bench;

  localparam int OP_W  = 4;
  localparam int FMT_W = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             inst_valid;
  logic [4:0]       inst_flags;
  logic [OP_W-1:0]  inst_op;
  logic [FMT_W-1:0] inst_fmt;
  logic             reg_wr_en;
  logic             reg_sel;
  logic [4:0]       reg_wdata;
  logic             trap_ack;

  logic             e_ready, l_ready;
  logic [4:0]       e_en, e_st, e_cur, e_cause;
  logic [4:0]       l_en, l_st, l_cur, l_cause;
  logic             e_req, l_req;
  logic [OP_W-1:0]  e_op, l_op;
  logic [FMT_W-1:0] e_fmt, l_fmt;

  fpx_trap_ctrl #(.OP_W(OP_W), .FMT_W(FMT_W), .LEVEL_MODE(0)) u_fpx_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_flags(inst_flags),
    .inst_op(inst_op), .inst_fmt(inst_fmt), .inst_ready(e_ready),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .exc_enable(e_en), .exc_sticky(e_st), .exc_current(e_cur),
    .trap_req(e_req), .trap_cause(e_cause), .trap_op(e_op), .trap_fmt(e_fmt),
    .trap_ack(trap_ack));

  fpx_trap_ctrl #(.OP_W(OP_W), .FMT_W(FMT_W), .LEVEL_MODE(1)) u_fpx_trap_ctrl_lvl (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_flags(inst_flags),
    .inst_op(inst_op), .inst_fmt(inst_fmt), .inst_ready(l_ready),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .exc_enable(l_en), .exc_sticky(l_st), .exc_current(l_cur),
    .trap_req(l_req), .trap_cause(l_cause), .trap_op(l_op), .trap_fmt(l_fmt),
    .trap_ack(trap_ack));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic sel, input logic [4:0] d);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic issue(input logic [4:0] f, input logic [OP_W-1:0] op, input logic [FMT_W-1:0] fm);
    inst_valid = 1'b1; inst_flags = f; inst_op = op; inst_fmt = fm;
    @(negedge clk);
    inst_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  function automatic logic [4:0] expect_cause(input logic [4:0] hit);
    logic [4:0] c;
    c = hit;
    if (hit[2] || hit[1]) c[0] = 1'b0;
    return c;
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; inst_valid = 1'b0; inst_flags = '0; inst_op = '0; inst_fmt = '0;
    reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wdata = '0; trap_ack = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 enable", e_en, 0);
    chk("R1 sticky", e_st, 0);
    chk("R1 current", e_cur, 0);
    chk("R1 trap_req", e_req, 0);
    chk("R1 cause", e_cause, 0);
    chk("R1 level trap_req", l_req, 0);
    rst_n = 1'b1;
    idle(1);

    // R3 R5 R6 R8 R11: sweep every enable mask against every flag pattern
    for (int e = 0; e < 32; e++) begin
      reg_write(1'b0, 5'(e));
      chk("R11 enable write", e_en, e);
      for (int f = 0; f < 32; f++) begin
        logic [4:0] hit;
        logic [4:0] c;
        logic [OP_W-1:0] op;
        logic [FMT_W-1:0] fm;
        reg_write(1'b1, 5'd0);
        op  = OP_W'((e + f) % 16);
        fm  = FMT_W'(f % 4);
        hit = 5'(e) & 5'(f);
        c   = expect_cause(hit);
        issue(5'(f), op, fm);
        chk("R2 current", e_cur, f);
        chk("R3 trap_req", e_req, (hit != 0));
        chk("R6 cause", e_cause, c);
        chk("R5 sticky", e_st, 5'(f) & ~c);
        chk("R8 ready", e_ready, (hit == 0));
        if (hit != 0) begin
          chk("R3 op", e_op, op);
          chk("R3 fmt", e_fmt, fm);
          issue(~5'(f), ~op, ~fm);
          chk("R8 blocked current", e_cur, f);
          chk("R8 blocked sticky", e_st, 5'(f) & ~c);
          chk("R7 held req", e_req, 1);
          chk("R7 held cause", e_cause, c);
          pulse_ack();
          chk("R7 released", e_req, 0);
          chk("R7 cause cleared", e_cause, 0);
        end
      end
    end

    // R4 and R10: enable traps over set sticky flags
    do_reset();
    reg_write(1'b1, 5'h1F);
    idle(1);
    chk("R4 sticky write", e_req, 0);
    chk("R10 sticky without enable", l_req, 0);
    reg_write(1'b0, 5'h1F);
    idle(1);
    chk("R4 enable write", e_req, 0);
    chk("R10 raised after enable", l_req, 1);
    chk("R10 cause", l_cause, 5'h1E);
    chk("R10 op", l_op, 0);
    idle(1);
    chk("R4 still quiet", e_req, 0);
    pulse_ack();
    chk("R10 released", l_req, 0);
    idle(1);
    chk("R10 repeats", l_req, 1);
    trap_ack = 1'b1; reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 5'd0;
    @(negedge clk);
    trap_ack = 1'b0; reg_wr_en = 1'b0;
    idle(2);
    chk("R10 cleared by handler", l_req, 0);
    chk("R10 sticky cleared", l_st, 0);

    // R9: write and completion in one cycle
    reg_write(1'b0, 5'd0);
    inst_valid = 1'b1; inst_flags = 5'b00001;
    reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 5'b00100;
    @(negedge clk);
    inst_valid = 1'b0; reg_wr_en = 1'b0;
    chk("R9 merge", e_st, 5'b00101);
    inst_valid = 1'b1; inst_flags = 5'b00010;
    reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 5'b00000;
    @(negedge clk);
    inst_valid = 1'b0; reg_wr_en = 1'b0;
    chk("R9 clear then set", e_st, 5'b00010);
    chk("R11 enable untouched", e_en, 0);

    // R1 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 sticky async", e_st, 0);
    chk("R1 current async", e_cur, 0);
    chk("R1 level sticky async", l_st, 0);
    idle(1);
    rst_n = 1'b1;
    idle(1);

    summary();
    $finish;
  end

endmodule